// File: doc/BRIEF.md
# Programmable Phase-Frequency Detector Controller

This block is the digital half of a synthesiser phase comparator. It takes two pulse streams, the divided reference and the divided RF feedback. A two-flop phase/frequency detector turns the relation between their rising edges into pump-up and pump-down commands for an analog charge pump. The same core drives a pair of monitor outputs and a filtered lock flag. A gain code is passed straight through to the analog current scaler.

A two-bit mode field sets what the detector and the monitor outputs do. In the first mode the detector runs and the monitors are silent. In the second both are live. In the third the detector runs until lock is reached and then goes quiet, so an external comparator can take over. In the fourth the detector is idle and the monitors are live. A sense bit exchanges the two inputs, and this reverses both the sign of the correction and which monitor shows which stream. While the programming strobe is high the pump commands are held inactive, so that a rewrite of the divider settings does not disturb the loop.

Top module: `pfd_ctrl`

## Requirements
- R1: Mode code 00: the detector drives `up_o`/`dn_o`, and `mon_ref_o` and `mon_div_o` stay low.
- R2: Mode code 01: the detector drives `up_o`/`dn_o`, and each monitor output repeats its selected input one clock later.
- R3: Mode code 10: the detector drives `up_o`/`dn_o` while `locked_o` is low and holds both low while `locked_o` is high; the monitors behave as in mode 01.
- R4: Mode code 11: `up_o` and `dn_o` stay low, and the monitors behave as in mode 01.
- R5: With `sense_i`=1 the RF input drives `up_o` and `mon_ref_o`, and the reference input drives `dn_o` and `mon_div_o`; with `sense_i`=0 the reference drives `up_o`/`mon_ref_o` and RF drives `dn_o`/`mon_div_o`.
- R6: A rising edge sampled on the up-side input raises `up_o` after that clock edge, and a rising edge on the down-side input does the same for `dn_o`. Once both are high they both clear on the next edge. The leading output is therefore high for d+1 cycles and the lagging one for 1 cycle, where d is the edge offset in cycles.
- R7: While `strobe_i` is high, `up_o` and `dn_o` are low.
- R8: `locked_o` rises at the end of the 16th consecutive comparison whose leading pulse lasts at most 2 cycles (offset d of 0 or 1).
- R9: A comparison whose leading pulse lasts 3 or more cycles (d of 2 or more) clears `locked_o` and restarts the count.
- R10: `gain_o` equals `gain_i`; the codes 00, 01, 10 and 11 request current factors of 1.0, 1.5, 2.5 and 4.0.
- R11: While `rst_n` is low, `up_o`, `dn_o`, `mon_ref_o`, `mon_div_o` and `locked_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_i | input | 1 | Divided reference pulse |
| rf_i | input | 1 | Divided RF pulse |
| mode_i | input | 2 | Detector/monitor mode |
| sense_i | input | 1 | Input swap |
| gain_i | input | 2 | Charge pump gain code |
| strobe_i | input | 1 | Programming strobe, gags the pump |
| up_o | output | 1 | Pump-up command |
| dn_o | output | 1 | Pump-down command |
| mon_ref_o | output | 1 | Monitor of the up-side input |
| mon_div_o | output | 1 | Monitor of the down-side input |
| locked_o | output | 1 | Filtered lock flag |
| gain_o | output | 2 | Gain code to the analog scaler |

## Verification
The comparison sweep covers every mode, both sense values, edge offsets of 0 to 2 cycles and both edge orders. Simultaneous edges show that the lagging pulse always lasts one cycle. The offset and order show which output leads and by how long, and the mode and sense show gating and swapping. Lock runs of 15 and 16 good comparisons locate the lock threshold. A 2- or 3-cycle offset after lock separates the width limit from the count. In mode 10 the gag after lock and the re-enable after a bad comparison are each observed on the pump outputs.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      PD_ON_MON_OFF = 2'b00,
      PD_ON_MON_ON  = 2'b01,
      PD_HANDOFF    = 2'b10,
      PD_OFF_MON_ON = 2'b11
   } pd_mode_e;
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic level_o,
   output logic rise_o
);
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level_o = sig_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], sig_i};
         end
         assign level_o = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_o;
   end

   assign rise_o = level_o & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_up_i,
   input  logic rise_dn_i,
   output logic up_q,
   output logic dn_q
);
   logic both_set;
   assign both_set = up_q & dn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (both_set) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_q | rise_up_i;
         dn_q <= dn_q | rise_dn_i;
      end
   end
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
   parameter int LOCK_COUNT = 16,
   parameter int MAX_WIDTH  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up_q,
   input  logic dn_q,
   output logic locked_o
);
   localparam int WW = $clog2(MAX_WIDTH + 2);
   localparam int CW = $clog2(LOCK_COUNT + 1);
   localparam logic [WW-1:0] W_MAX = WW'(MAX_WIDTH);
   localparam logic [WW-1:0] W_SAT = WW'(MAX_WIDTH + 1);
   localparam logic [CW-1:0] C_TOP = CW'(LOCK_COUNT);

   logic [WW-1:0] width_q;
   logic [CW-1:0] run_q;
   logic          done, active, good;

   assign done   = up_q & dn_q;
   assign active = up_q | dn_q;
   assign good   = (width_q < W_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q <= '0;
      end else if (done) begin
         width_q <= '0;
      end else if (active && width_q != W_SAT) begin
         width_q <= width_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= '0;
         locked_o <= 1'b0;
      end else if (done) begin
         if (good) begin
            if (run_q != C_TOP) run_q <= run_q + 1'b1;
            if (run_q + 1'b1 >= C_TOP) locked_o <= 1'b1;
         end else begin
            run_q    <= '0;
            locked_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl #(
   parameter int LOCK_COUNT  = 16,
   parameter int MAX_WIDTH   = 2,
   parameter int SYNC_STAGES = 0,
   parameter int GAIN_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_i,
   input  logic              rf_i,
   input  logic [1:0]        mode_i,
   input  logic              sense_i,
   input  logic [GAIN_W-1:0] gain_i,
   input  logic              strobe_i,
   output logic              up_o,
   output logic              dn_o,
   output logic              mon_ref_o,
   output logic              mon_div_o,
   output logic              locked_o,
   output logic [GAIN_W-1:0] gain_o
);
   import pfd_pkg::*;

   localparam int NCH = 2;

   generate
      if (LOCK_COUNT < 1) begin : g_bad_lock
         $error("LOCK_COUNT must be at least 1");
      end
      if (MAX_WIDTH < 1) begin : g_bad_width
         $error("MAX_WIDTH must be at least 1");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic [NCH-1:0] raw_in, lvl, rise;
   assign raw_in = {rf_i, ref_i};

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_edge
         pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .sig_i   (raw_in[ch]),
            .level_o (lvl[ch]),
            .rise_o  (rise[ch])
         );
      end
   endgenerate

   logic rise_up, rise_dn, lvl_up, lvl_dn;
   assign rise_up = sense_i ? rise[1] : rise[0];
   assign rise_dn = sense_i ? rise[0] : rise[1];
   assign lvl_up  = sense_i ? lvl[1]  : lvl[0];
   assign lvl_dn  = sense_i ? lvl[0]  : lvl[1];

   logic up_q, dn_q;
   pfd_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_up_i (rise_up),
      .rise_dn_i (rise_dn),
      .up_q      (up_q),
      .dn_q      (dn_q)
   );

   pfd_lock_filter #(.LOCK_COUNT(LOCK_COUNT), .MAX_WIDTH(MAX_WIDTH)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_q     (up_q),
      .dn_q     (dn_q),
      .locked_o (locked_o)
   );

   pd_mode_e mode;
   logic     det_en, mon_en;
   assign mode = pd_mode_e'(mode_i);

   always_comb begin
      det_en = 1'b1;
      mon_en = 1'b1;
      case (mode)
         PD_ON_MON_OFF: mon_en = 1'b0;
         PD_ON_MON_ON:  det_en = 1'b1;
         PD_HANDOFF:    det_en = ~locked_o;
         PD_OFF_MON_ON: det_en = 1'b0;
         default:       det_en = 1'b0;
      endcase
   end

   assign up_o   = up_q & det_en & ~strobe_i;
   assign dn_o   = dn_q & det_en & ~strobe_i;
   assign gain_o = gain_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_ref_o <= 1'b0;
         mon_div_o <= 1'b0;
      end else begin
         mon_ref_o <= mon_en & lvl_up;
         mon_div_o <= mon_en & lvl_dn;
      end
   end
endmodule

// File: rtl/pfd_ctrl_chk.sv
module pfd_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_i,
   input logic       rf_i,
   input logic [1:0] mode_i,
   input logic       sense_i,
   input logic       strobe_i,
   input logic       up_o,
   input logic       dn_o,
   input logic       mon_ref_o,
   input logic       mon_div_o,
   input logic       locked_o
);
   p_strobe_gag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |-> (!up_o && !dn_o));

   p_idle_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b11) |-> (!up_o && !dn_o));

   p_handoff_gag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b10 && locked_o) |-> (!up_o && !dn_o));

   p_mon_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00) |=> (!mon_ref_o && !mon_div_o));

   p_mon_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01 && !sense_i) |=> (mon_ref_o == $past(ref_i) && mon_div_o == $past(rf_i)));

   p_mon_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'b00 && sense_i) |=> (mon_ref_o == $past(rf_i) && mon_div_o == $past(ref_i)));

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o && dn_o) |=> !(up_o && dn_o));
endmodule

bind pfd_ctrl pfd_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_i     (ref_i),
   .rf_i      (rf_i),
   .mode_i    (mode_i),
   .sense_i   (sense_i),
   .strobe_i  (strobe_i),
   .up_o      (up_o),
   .dn_o      (dn_o),
   .mon_ref_o (mon_ref_o),
   .mon_div_o (mon_div_o),
   .locked_o  (locked_o)
);

// File: tb/pfd_ctrl_bench.sv
module pfd_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_i = 1'b0, rf_i = 1'b0;
   logic [1:0] mode_i = 2'b01;
   logic       sense_i = 1'b0;
   logic [1:0] gain_i = 2'b00;
   logic       strobe_i = 1'b0;
   logic       up_o, dn_o, mon_ref_o, mon_div_o, locked_o;
   logic [1:0] gain_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pfd_ctrl u_pfd_ctrl (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .rf_i(rf_i),
      .mode_i(mode_i), .sense_i(sense_i), .gain_i(gain_i), .strobe_i(strobe_i),
      .up_o(up_o), .dn_o(dn_o), .mon_ref_o(mon_ref_o), .mon_div_o(mon_div_o),
      .locked_o(locked_o), .gain_o(gain_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Starts and ends at a falling edge; counts cycles with up/dn high.
   task automatic run_cmp(input int d, input bit ref_first, output int nu, output int nd);
      nu = 0; nd = 0;
      for (int i = 0; i <= d + 6; i++) begin
         if (i == 0) begin
            if (ref_first) ref_i = 1'b1; else rf_i = 1'b1;
         end
         if (i == d) begin
            if (ref_first) rf_i = 1'b1; else ref_i = 1'b1;
         end
         if (i == d + 3) begin
            ref_i = 1'b0; rf_i = 1'b0;
         end
         @(posedge clk); #1;
         if (up_o) nu++;
         if (dn_o) nd++;
         @(negedge clk);
      end
   endtask

   task automatic mon_test(input logic [1:0] m, input bit s, input string req);
      int er, ed;
      mode_i = m; sense_i = s;
      @(negedge clk);
      ref_i = 1'b1;
      @(posedge clk); #1;
      er = (m == 2'b00) ? 0 : (s ? 0 : 1);
      ed = (m == 2'b00) ? 0 : (s ? 1 : 0);
      chk(mon_ref_o == er[0], {req, " mon_ref ref-high"}, mon_ref_o, er);
      chk(mon_div_o == ed[0], {req, " mon_div ref-high"}, mon_div_o, ed);
      @(negedge clk);
      ref_i = 1'b0; rf_i = 1'b1;
      @(posedge clk); #1;
      er = (m == 2'b00) ? 0 : (s ? 1 : 0);
      ed = (m == 2'b00) ? 0 : (s ? 0 : 1);
      chk(mon_ref_o == er[0], {req, " mon_ref rf-high"}, mon_ref_o, er);
      chk(mon_div_o == ed[0], {req, " mon_div rf-high"}, mon_div_o, ed);
      @(negedge clk);
      rf_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int nu, nd, eu, ed;
      // R11: reset state
      repeat (3) @(negedge clk);
      chk({up_o, dn_o, mon_ref_o, mon_div_o, locked_o} == 5'b0, "R11 reset outputs",
          {up_o, dn_o, mon_ref_o, mon_div_o, locked_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2 R4 R5 R6: sweep of modes 00, 01, 11 (10 covered in lock part)
      for (int m = 0; m < 4; m++) begin
         if (m == 2) continue;
         for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 3; d++) begin
               for (int o = 0; o < 2; o++) begin
                  mode_i = 2'(m); sense_i = s[0];
                  run_cmp(d, o[0], nu, nd);
                  if (m == 3) begin
                     eu = 0; ed = 0;
                  end else if ((o != 0) ^ (s != 0)) begin
                     eu = d + 1; ed = 1;
                  end else begin
                     eu = 1; ed = d + 1;
                  end
                  chk(nu == eu, (m == 3) ? "R4 up idle" : "R6/R5 up width", nu, eu);
                  chk(nd == ed, (m == 3) ? "R4 dn idle" : "R6/R5 dn width", nd, ed);
               end
            end
         end
      end

      // Monitor outputs: R1 quiet, R2 follow, R3/R4 monitors live, R5 swap
      mon_test(2'b00, 1'b0, "R1");
      mon_test(2'b00, 1'b1, "R1");
      mon_test(2'b01, 1'b0, "R2");
      mon_test(2'b01, 1'b1, "R5");
      mon_test(2'b10, 1'b0, "R3");
      mon_test(2'b11, 1'b1, "R4");

      // R7: strobe gags the pump
      mode_i = 2'b01; sense_i = 1'b0; strobe_i = 1'b1;
      run_cmp(1, 1'b1, nu, nd);
      chk(nu == 0 && nd == 0, "R7 strobe gag", nu + nd, 0);
      strobe_i = 1'b0;

      // R8 / R9: lock threshold and drop
      run_cmp(2, 1'b1, nu, nd);
      chk(locked_o == 1'b0, "R9 cleared before run", locked_o, 0);
      for (int k = 0; k < 15; k++) run_cmp(k % 2, 1'b1, nu, nd);
      chk(locked_o == 1'b0, "R8 not locked after 15", locked_o, 0);
      run_cmp(1, 1'b0, nu, nd);
      chk(locked_o == 1'b1, "R8 locked after 16", locked_o, 1);
      run_cmp(3, 1'b1, nu, nd);
      chk(nu == 4 && nd == 1, "R6 wide pulse in mode 01", nu, 4);
      chk(locked_o == 1'b0, "R9 dropped after wide pulse", locked_o, 0);

      // R3: hand-off mode
      mode_i = 2'b10;
      for (int k = 0; k < 16; k++) run_cmp(1, 1'b1, nu, nd);
      chk(locked_o == 1'b1, "R3 locked in hand-off", locked_o, 1);
      run_cmp(1, 1'b1, nu, nd);
      chk(nu == 0 && nd == 0, "R3 gagged after lock", nu + nd, 0);
      chk(locked_o == 1'b1, "R3 lock held", locked_o, 1);
      run_cmp(2, 1'b1, nu, nd);
      chk(nu == 0 && nd == 0, "R3 gagged during bad compare", nu + nd, 0);
      chk(locked_o == 1'b0, "R9 drop in hand-off", locked_o, 0);
      run_cmp(1, 1'b1, nu, nd);
      chk(nu == 2 && nd == 1, "R3 re-enabled after drop", nu * 10 + nd, 21);

      // R10: gain pass-through
      for (int g = 0; g < 4; g++) begin
         gain_i = 2'(g);
         @(negedge clk);
         chk(gain_o == 2'(g), "R10 gain code", gain_o, g);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule